// File: doc/BRIEF.md
# Delta-Sigma ADC Frame Reader

This block is an SPI master that pulls conversion frames out of a multichannel delta-sigma ADC. Every frame is a 24-bit status header followed by one sample per channel. Each word is handed downstream on a valid/ready stream: the status word first, then the channels in ascending order, with a last flag on the final channel. The serial clock is made by dividing the system clock. The divider is clamped so that SCLK never runs faster than the limit for the selected supply setting.

Two read modes exist. In continuous mode the ADC signals a finished conversion with a falling edge on its active-low data-ready line, and every such edge starts a read. If a new edge arrives while a frame is still being shifted, the frame is lost. The block raises a sticky overrun flag, drops the rest of that frame and reads the new one. In on-demand mode a request pulse starts the read: an 8-bit read opcode goes out on MOSI, and the frame follows while chip select stays low. The ADC only loads data when asked, so data-ready edges cannot corrupt a read and no overrun is ever flagged in this mode.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, the output is not valid and the overrun flag is clear.
- R2: In continuous mode, each data-ready falling edge starts one frame. Chip select stays low for exactly 24 + NUM_CH x SAMPLE_W SCLK cycles, which is 216 with the defaults.
- R3: SPI mode 1 is used: MISO is sampled on the falling SCLK edge, most significant bit first. The words come out in this order: the status word, then channel 0 up to channel NUM_CH-1. Each word appears once. A sample is right-aligned in the 24-bit output word, with its upper bits zero.
- R4: The last flag is set on the final channel word of a frame and on no other word.
- R5: The first SCLK rising edge comes at least DELAY_CYC = 4 x ADC_CLK_DIV system cycles after chip select falls. Chip select falls within three cycles of the data-ready edge, so the whole delay from the edge to the first rising edge is 8 to 12 cycles with the defaults.
- R6: The high and low phases of SCLK inside a frame each last at least HALF_CYC system cycles. HALF_CYC is the larger of SCLK_HALF_DIV and the number of half periods needed for the minimum SCLK period: 50 ns normally, 66.6 ns when LOW_SUPPLY is set.
- R7: SCLK is low whenever chip select is high.
- R8: In on-demand mode, a readReq pulse starts a read. READ_OPCODE (default 0x12) is shifted out on MOSI, most significant bit first, changing on the rising edges of the first 8 SCLK cycles. The frame then follows without chip select rising, for 8 + 216 cycles in total.
- R9: readReq has no effect in continuous mode. Data-ready edges have no effect on an on-demand read and never set the overrun flag.
- R10: In continuous mode, a data-ready edge during a frame sets the overrun flag. The remaining words of that frame are dropped, so no last flag is emitted for it, and the new frame is read in full. The flag stays set through later frames.
- R11: A pulse on overrunClr clears the overrun flag.
- R12: While outValid is high and outReady is low, outData and outLast hold. If the next word finishes while the output is still full, SCLK stops and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeOnDemand | input | 1 | 1 = on-demand reads, 0 = continuous reads |
| readReq | input | 1 | Read request pulse (on-demand mode) |
| drdyN | input | 1 | Active-low data-ready from the ADC (asynchronous) |
| miso | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the ADC (read opcode) |
| outData | output | 24 | Word on the output stream |
| outValid | output | 1 | Output word valid |
| outLast | output | 1 | Word is the final channel of its frame |
| outReady | input | 1 | Downstream accepts the word |
| overrun | output | 1 | Sticky frame-overrun flag |
| overrunClr | input | 1 | Clears the overrun flag |

## Verification
Four properties are checked on every cycle:
- the SCLK phase lengths against the clamped divider;
- the quiet SCLK while chip select is high;
- the wait before the first SCLK edge of a frame;
- the output holding steady under backpressure, and the overrun flag's stickiness and its absence in on-demand mode.

Some behaviour can only be shown by the bench's scenarios, because it needs a model of the ADC. That covers the bit order and word contents, the frame length, the opcode on MOSI, and what follows an overrun: which words are dropped and which are kept.

// File: rtl/afr_pkg.sv
package afr_pkg;

  localparam int STATUS_W = 24;
  localparam int OP_W     = 8;
  localparam int OUT_W    = 24;

  // strobes from the sequencer to the shifting datapath
  typedef struct packed {
    logic csAssert;
    logic csRelease;
    logic sclkRise;
    logic sclkFall;
    logic loadOp;
    logic shiftOp;
    logic capture;
    logic push;
    logic pushStatus;
    logic pushLast;
  } afr_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_HIGH,
    ST_LOW,
    ST_PUSH,
    ST_FINISH
  } afr_state_t;

endpackage

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int SAMPLE_W  = 24,
  parameter int HALF_CYC  = 3,
  parameter int DELAY_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeOnDemand,
  input  logic        readReq,
  input  logic        drdyN,
  input  logic        overrunClr,
  input  logic        outFree,
  output afr_strobe_t strb,
  output logic        overrun
);

  localparam int TMR_MAX = (DELAY_CYC > HALF_CYC) ? DELAY_CYC : HALF_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BIT_W   = $clog2(STATUS_W + 1);
  localparam int IDX_W   = $clog2(NUM_CH + 1);

  afr_state_t       state, stateNext;
  logic [TMR_W-1:0] tmr, tmrNext;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [IDX_W-1:0] wordIdx, idxNext;
  logic             inOpcode, opNext;
  logic             frameOd, odNext;
  logic             restart, restartNext;
  logic             ovrSet;
  logic [2:0]       drdySync;
  logic             drdyFall;
  logic             startEvt;
  logic             busy;
  logic             collide;
  logic [BIT_W-1:0] wordLastBit;

  // bring the asynchronous data-ready line into the clock domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drdySync <= '1;
    else       drdySync <= {drdySync[1:0], drdyN};
  end

  assign drdyFall = drdySync[2] & ~drdySync[1];
  assign startEvt = modeOnDemand ? readReq : drdyFall;
  assign busy     = (state == ST_DELAY) || (state == ST_HIGH) ||
                    (state == ST_LOW)   || (state == ST_PUSH);
  assign collide  = drdyFall && !modeOnDemand && !frameOd && busy;

  always_comb begin
    if (inOpcode)          wordLastBit = BIT_W'(OP_W - 1);
    else if (wordIdx == 0) wordLastBit = BIT_W'(STATUS_W - 1);
    else                   wordLastBit = BIT_W'(SAMPLE_W - 1);
  end

  always_comb begin
    strb        = '0;
    stateNext   = state;
    tmrNext     = tmr;
    bitNext     = bitCnt;
    idxNext     = wordIdx;
    opNext      = inOpcode;
    odNext      = frameOd;
    restartNext = restart;
    ovrSet      = 1'b0;
    if (collide) begin
      // frame overwritten by the converter: abandon it and read the new one
      ovrSet         = 1'b1;
      strb.sclkFall  = 1'b1;
      strb.csRelease = 1'b1;
      restartNext    = 1'b1;
      stateNext      = ST_FINISH;
    end else begin
      unique case (state)
        ST_IDLE, ST_FINISH: begin
          if (startEvt || (state == ST_FINISH && restart)) begin
            strb.csAssert = 1'b1;
            strb.loadOp   = modeOnDemand;
            opNext        = modeOnDemand;
            odNext        = modeOnDemand;
            idxNext       = '0;
            bitNext       = '0;
            tmrNext       = TMR_W'(DELAY_CYC - 1);
            restartNext   = 1'b0;
            stateNext     = ST_DELAY;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_DELAY, ST_LOW: begin
          if (tmr == '0) begin
            strb.sclkRise = 1'b1;
            strb.shiftOp  = inOpcode;
            tmrNext       = TMR_W'(HALF_CYC - 1);
            stateNext     = ST_HIGH;
          end else begin
            tmrNext = tmr - 1'b1;
          end
        end
        ST_HIGH: begin
          if (tmr == '0) begin
            strb.sclkFall = 1'b1;
            strb.capture  = 1'b1;
            if (bitCnt == wordLastBit) begin
              bitNext   = '0;
              stateNext = ST_PUSH;
            end else begin
              bitNext   = bitCnt + 1'b1;
              tmrNext   = TMR_W'(HALF_CYC - 1);
              stateNext = ST_LOW;
            end
          end else begin
            tmrNext = tmr - 1'b1;
          end
        end
        ST_PUSH: begin
          if (inOpcode) begin
            opNext    = 1'b0;
            tmrNext   = TMR_W'(HALF_CYC - 1);
            stateNext = ST_LOW;
          end else if (outFree) begin
            strb.push       = 1'b1;
            strb.pushStatus = (wordIdx == '0);
            strb.pushLast   = (wordIdx == IDX_W'(NUM_CH));
            if (wordIdx == IDX_W'(NUM_CH)) begin
              strb.csRelease = 1'b1;
              stateNext      = ST_FINISH;
            end else begin
              idxNext   = wordIdx + 1'b1;
              tmrNext   = TMR_W'(HALF_CYC - 1);
              stateNext = ST_LOW;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      bitCnt   <= '0;
      wordIdx  <= '0;
      inOpcode <= 1'b0;
      frameOd  <= 1'b0;
      restart  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      state    <= stateNext;
      tmr      <= tmrNext;
      bitCnt   <= bitNext;
      wordIdx  <= idxNext;
      inOpcode <= opNext;
      frameOd  <= odNext;
      restart  <= restartNext;
      if (ovrSet)          overrun <= 1'b1;
      else if (overrunClr) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/afr_datapath.sv
module afr_datapath
  import afr_pkg::*;
#(
  parameter int              SAMPLE_W    = 24,
  parameter logic [OP_W-1:0] READ_OPCODE = 8'h12
) (
  input  logic             clk,
  input  logic             rstN,
  input  afr_strobe_t      strb,
  input  logic             miso,
  input  logic             outReady,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  output logic [OUT_W-1:0] outData,
  output logic             outValid,
  output logic             outLast,
  output logic             outFree
);

  localparam logic [OUT_W-1:0] SAMPLE_MASK = {OUT_W{1'b1}} >> (OUT_W - SAMPLE_W);

  logic [OUT_W-1:0] shiftReg;
  logic [OP_W-1:0]  opReg;

  assign outFree = !outValid || outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk <= 1'b0;
      csN  <= 1'b1;
    end else begin
      if (strb.sclkRise)      sclk <= 1'b1;
      else if (strb.sclkFall) sclk <= 1'b0;
      if (strb.csAssert)       csN <= 1'b0;
      else if (strb.csRelease) csN <= 1'b1;
    end
  end

  // opcode leaves on rising edges, MSB first; MOSI rests low otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= '0;
      mosi  <= 1'b0;
    end else begin
      if (strb.loadOp) opReg <= READ_OPCODE;
      else if (strb.shiftOp) opReg <= {opReg[OP_W-2:0], 1'b0};
      if (strb.shiftOp) mosi <= opReg[OP_W-1];
      else if (strb.sclkRise || strb.csRelease) mosi <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.capture) shiftReg <= {shiftReg[OUT_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else if (strb.push) begin
      outData  <= strb.pushStatus ? shiftReg : (shiftReg & SAMPLE_MASK);
      outValid <= 1'b1;
      outLast  <= strb.pushLast;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import afr_pkg::*;
#(
  parameter int              NUM_CH        = 8,
  parameter int              SAMPLE_W      = 24,
  parameter int              SYS_PERIOD_PS = 10000,
  parameter bit              LOW_SUPPLY    = 1'b0,
  parameter int              SCLK_HALF_DIV = 2,
  parameter int              ADC_CLK_DIV   = 2,
  parameter logic [OP_W-1:0] READ_OPCODE   = 8'h12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeOnDemand,
  input  logic             readReq,
  input  logic             drdyN,
  input  logic             miso,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  output logic [OUT_W-1:0] outData,
  output logic             outValid,
  output logic             outLast,
  input  logic             outReady,
  output logic             overrun,
  input  logic             overrunClr
);

  localparam int MIN_PERIOD_PS = LOW_SUPPLY ? 66600 : 50000;
  localparam int MIN_HALF      = (MIN_PERIOD_PS + 2 * SYS_PERIOD_PS - 1) / (2 * SYS_PERIOD_PS);
  localparam int HALF_CYC      = (SCLK_HALF_DIV > MIN_HALF) ? SCLK_HALF_DIV : MIN_HALF;
  localparam int DELAY_CYC     = 4 * ADC_CLK_DIV;

  afr_strobe_t strb;
  logic        outFree;

  afr_ctrl #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .HALF_CYC (HALF_CYC),
    .DELAY_CYC(DELAY_CYC)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeOnDemand(modeOnDemand),
    .readReq     (readReq),
    .drdyN       (drdyN),
    .overrunClr  (overrunClr),
    .outFree     (outFree),
    .strb        (strb),
    .overrun     (overrun)
  );

  afr_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .READ_OPCODE(READ_OPCODE)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .miso    (miso),
    .outReady(outReady),
    .sclk    (sclk),
    .csN     (csN),
    .mosi    (mosi),
    .outData (outData),
    .outValid(outValid),
    .outLast (outLast),
    .outFree (outFree)
  );

endmodule

// File: rtl/afr_checker.sv
module afr_checker
  import afr_pkg::*;
#(
  parameter int HALF_CYC  = 3,
  parameter int DELAY_CYC = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclk,
  input logic             csN,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData,
  input logic             outLast,
  input logic             overrun,
  input logic             overrunClr,
  input logic             modeOnDemand
);

  logic        sclkQ;
  logic [7:0]  phaseCnt;
  logic [15:0] sinceCs;
  logic        hadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      phaseCnt <= '1;
      sinceCs  <= '0;
      hadRise  <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (sclk != sclkQ)     phaseCnt <= 8'd1;
      else if (phaseCnt != '1) phaseCnt <= phaseCnt + 1'b1;
      if (csN)               sinceCs <= '0;
      else if (sinceCs != '1) sinceCs <= sinceCs + 1'b1;
      if (csN)       hadRise <= 1'b0;
      else if (sclk) hadRise <= 1'b1;
    end
  end

  a_r6_phase_min: assert property (@(posedge clk) disable iff (!rstN)
    (sclk != sclkQ) && !csN |-> phaseCnt >= 8'(HALF_CYC));

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  a_r5_first_edge_delay: assert property (@(posedge clk) disable iff (!rstN)
    !csN && sclk && !sclkQ && !hadRise |-> sinceCs >= 16'(DELAY_CYC));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !overrunClr |=> overrun);

  a_r9_od_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    modeOnDemand && !overrun |=> !overrun);

endmodule

bind adc_frame_reader afr_checker #(
  .HALF_CYC (HALF_CYC),
  .DELAY_CYC(DELAY_CYC)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .sclk        (sclk),
  .csN         (csN),
  .outValid    (outValid),
  .outReady    (outReady),
  .outData     (outData),
  .outLast     (outLast),
  .overrun     (overrun),
  .overrunClr  (overrunClr),
  .modeOnDemand(modeOnDemand)
);

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_frame_reader;

  localparam int NCH  = 8;
  localparam int SW   = 24;
  localparam int HALF = 3;
  localparam int DLY  = 8;
  localparam logic [7:0] OPC = 8'h12;
  localparam int FBITS = 24 + NCH * SW;

  logic clk = 1'b0;
  logic rstN, modeOnDemand, readReq, drdyN, miso, outReady, overrunClr;
  logic sclk, csN, mosi, outValid, outLast, overrun;
  logic [23:0] outData;

  always #5 clk = ~clk;

  adc_frame_reader dut (
    .clk(clk), .rstN(rstN), .modeOnDemand(modeOnDemand), .readReq(readReq),
    .drdyN(drdyN), .miso(miso), .sclk(sclk), .csN(csN), .mosi(mosi),
    .outData(outData), .outValid(outValid), .outLast(outLast),
    .outReady(outReady), .overrun(overrun), .overrunClr(overrunClr)
  );

  int checks = 0;
  int errors = 0;

  // ADC model state
  logic [23:0] expW [NCH+1];
  logic [23:0] lw   [NCH+1];
  int  rcnt = 0;
  int  off  = 0;
  logic [7:0] opCap = 8'h00;
  int  lastRises = 0;
  longint tDr = 0;
  int  dlyCyc = 0;

  // stream collection
  logic [23:0] rxData [$];
  logic        rxLast [$];
  int  lastCnt = 0;
  int  readyMode = 0;
  int  runLen = 1000;
  int  minPhase = 1000;
  logic prevSclk = 1'b0;

  function automatic logic [23:0] maskS(input logic [23:0] v);
    return v & (24'hFFFFFF >> (24 - SW));
  endfunction

  function automatic logic [23:0] expWord(input int k);
    return (k == 0) ? expW[0] : maskS(expW[k]);
  endfunction

  function automatic logic frameBit(input int i);
    int j;
    if (i < 24) return lw[0][23-i];
    j = i - 24;
    if (j >= NCH * SW) return 1'b0;
    return lw[1 + j / SW][SW - 1 - (j % SW)];
  endfunction

  // ADC: load at chip select fall, drive on rising SCLK
  always @(negedge csN or posedge sclk) begin
    if (sclk && !csN) begin
      if (rcnt == 0) dlyCyc = int'(($time - tDr) / 10);
      if (rcnt >= off) miso <= frameBit(rcnt - off);
      rcnt = rcnt + 1;
    end else if (!csN) begin
      for (int k = 0; k <= NCH; k++) lw[k] = expW[k];
      rcnt = 0;
      off  = modeOnDemand ? 8 : 0;
    end
  end

  always @(negedge sclk) begin
    if (!csN && off == 8 && rcnt >= 1 && rcnt <= 8) opCap = {opCap[6:0], mosi};
  end

  always @(posedge csN) lastRises = rcnt;
  always @(negedge drdyN) tDr = $time;

  // consumer and SCLK phase monitor, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      case (readyMode)
        0:       outReady = 1'b1;
        1:       outReady = 1'($urandom % 2);
        default: outReady = 1'b0;
      endcase
      if (outValid && outReady) begin
        rxData.push_back(outData);
        rxLast.push_back(outLast);
        if (outLast) lastCnt++;
      end
      if (sclk != prevSclk) begin
        if (!csN && runLen < minPhase) minPhase = runLen;
        runLen = 1;
      end else begin
        runLen++;
      end
      prevSclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic newFrame();
    for (int k = 0; k <= NCH; k++) expW[k] = 24'($urandom);
  endtask

  task automatic drdyPulse();
    @(negedge clk); drdyN = 1'b0;
    repeat (4) @(negedge clk);
    drdyN = 1'b1;
  endtask

  task automatic waitLast(input int target);
    for (int n = 0; n < 6000 && lastCnt < target; n++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrame(input int start);
    chk(rxData.size() >= start + NCH + 1, "R3", "word count",
        rxData.size() - start, NCH + 1);
    if (rxData.size() >= start + NCH + 1) begin
      for (int k = 0; k <= NCH; k++) begin
        chk(rxData[start+k] == expWord(k), "R3", "word", rxData[start+k], expWord(k));
        chk(rxLast[start+k] == (k == NCH), "R4", "last flag", rxLast[start+k], (k == NCH));
      end
    end
  endtask

  task automatic contFrame();
    int s0, l0;
    s0 = rxData.size(); l0 = lastCnt;
    newFrame();
    drdyPulse();
    waitLast(l0 + 1);
    checkFrame(s0);
    chk(lastRises == FBITS, "R2", "sclk cycles per frame", lastRises, FBITS);
    chk(dlyCyc >= DLY && dlyCyc <= DLY + 4, "R5", "edge to first sclk", dlyCyc, DLY);
  endtask

  task automatic odFrame(input bit poke);
    int s0, l0;
    s0 = rxData.size(); l0 = lastCnt;
    newFrame();
    @(negedge clk); readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      drdyPulse();
    end
    waitLast(l0 + 1);
    checkFrame(s0);
    chk(opCap == OPC, "R8", "read opcode", opCap, OPC);
    chk(lastRises == FBITS + 8, "R8", "sclk cycles incl opcode", lastRises, FBITS + 8);
    if (poke) chk(overrun == 1'b0, "R9", "overrun in on-demand", overrun, 0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed, s0, l0, k;
    seed = $urandom(32'd20240611);
    rstN = 1'b0; modeOnDemand = 1'b0; readReq = 1'b0; drdyN = 1'b1;
    miso = 1'b0; overrunClr = 1'b0; outReady = 1'b1;
    for (int i = 0; i <= NCH; i++) expW[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1", "csN", csN, 1);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1", "sclk/mosi", {sclk, mosi}, 0);
    chk(outValid == 1'b0, "R1", "outValid", outValid, 0);
    chk(overrun == 1'b0, "R1", "overrun", overrun, 0);

    // R2 R3 R4 R5: continuous frames, random backpressure
    readyMode = 1;
    for (int f = 0; f < 4; f++) contFrame();

    // R12: downstream never ready, SCLK must stop after two words
    readyMode = 2;
    s0 = rxData.size(); l0 = lastCnt;
    newFrame();
    drdyPulse();
    repeat (2500) @(negedge clk);
    chk(rcnt == 24 + SW, "R12", "sclk cycles while stalled", rcnt, 24 + SW);
    chk(csN == 1'b0 && outValid == 1'b1, "R12", "held word", {csN, outValid}, 1);
    readyMode = 0;
    waitLast(l0 + 1);
    checkFrame(s0);

    // R9: read request ignored in continuous mode
    @(negedge clk); readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
    k = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (!csN) k++;
    end
    chk(k == 0, "R9", "cycles with csN low after readReq", k, 0);

    // R10: data-ready edge mid-frame
    readyMode = 0;
    s0 = rxData.size(); l0 = lastCnt;
    newFrame();
    drdyPulse();
    repeat (400) @(negedge clk);
    begin
      logic [23:0] aW [NCH+1];
      for (int i = 0; i <= NCH; i++) aW[i] = expWord(i);
      newFrame();
      drdyPulse();
      repeat (3) @(negedge clk);
      chk(overrun == 1'b1, "R10", "overrun set", overrun, 1);
      waitLast(l0 + 1);
      chk(lastCnt == l0 + 1, "R10", "last flags after overrun", lastCnt - l0, 1);
      k = rxData.size() - s0 - (NCH + 1);
      chk(k >= 1 && k <= NCH, "R10", "partial words kept", k, 2);
      for (int i = 0; i < k && i <= NCH; i++)
        chk(rxData[s0+i] == aW[i], "R10", "partial word", rxData[s0+i], aW[i]);
      if (k >= 0) checkFrame(s0 + k);
    end
    contFrame();
    chk(overrun == 1'b1, "R10", "overrun sticky", overrun, 1);

    // R11: clear
    @(negedge clk); overrunClr = 1'b1;
    @(negedge clk); overrunClr = 1'b0;
    chk(overrun == 1'b0, "R11", "overrun cleared", overrun, 0);

    // R8 R9: on-demand reads, one disturbed by a data-ready edge
    modeOnDemand = 1'b1;
    readyMode = 1;
    odFrame(1'b0);
    odFrame(1'b1);

    // R6: SCLK phase lengths seen at the pins
    chk(minPhase >= HALF, "R6", "shortest sclk phase", minPhase, HALF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule